// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches an already-synchronised bank of general purpose input pins and turns selected pin activity into interrupt requests. Each pin is configured on its own: it may report while it sits at a chosen level, or it may catch a chosen transition (rising, falling, or either). A transition is captured in a sticky flag that holds until software acknowledges it. A level condition is reported only while it lasts.

The captured and level-driven conditions form a raw status word. An enable mask filters it into a masked status word, and any set masked bit raises the single interrupt line. Software drives a small synchronous register port. It has one write strobe, a word index and a write data word. Read data is combinational on the index.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the mode, both-edge, polarity and enable registers read 0, no edge flag is held, and `irq_out` is 0.
- R2: Register indices on `bus_addr`: 0 mode (1 = level, 0 = edge), 1 both-edge select, 2 polarity, 3 enable, 4 raw status, 5 masked status, 6 acknowledge, 7 unused. Indices 0 to 3 read back the last value written. Writes to 4 and 5 change nothing. Indices 6 and 7 read 0.
- R3: For a level-mode pin, raw status bit = 1 exactly while the pin equals its polarity bit, in the same cycle with no clock edge. It drops with the condition and needs no acknowledge.
- R4: For an edge-mode pin with both-edge = 0, polarity 1 captures a 0→1 change and polarity 0 captures a 1→0 change. The change is detected against the pin value of the previous cycle, and the flag reads 1 after the first clock edge that sees the change. The opposite transition captures nothing.
- R5: For an edge-mode pin with both-edge = 1, either transition is captured and the polarity bit is ignored.
- R6: A captured edge flag holds over any number of cycles until a write to index 6 with that bit = 1 clears it. Acknowledge bits of 0 leave flags alone.
- R7: If a captured transition and an acknowledge of the same pin fall in the same cycle, the flag ends set.
- R8: Rewriting mode, both-edge or polarity does not clear captured edge flags. A pin switched to level mode and back to edge mode shows its flag again.
- R9: Masked status = raw status AND enable, and `irq_out` is the OR of the masked status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Synchronised pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle, assertions check four things. A flag is never set without a detected transition in the previous cycle. A held flag survives any cycle that lacks an acknowledge of it. An acknowledge without a coincident transition clears the flag. A zero enable mask keeps the interrupt line low. They also check that reset leaves the configuration clear and that writes to the status indices leave the configuration untouched. Some behaviour can only be shown by the bench's scenarios, because it depends on the configuration history: the exact cycle a capture becomes visible, the polarity choice for single edges, flags coming back after a pin returns from level mode, and the acknowledge-versus-transition collision seen at the port.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_MODE   = 3'd0,
    REG_BOTH   = 3'd1,
    REG_POL    = 3'd2,
    REG_EN     = 3'd3,
    REG_RAW    = 3'd4,
    REG_MASKED = 3'd5,
    REG_ACK    = 3'd6,
    REG_SPARE  = 3'd7
  } reg_sel_e;

  // Transition test: current sample against the previous cycle's sample.
  function automatic logic edge_event(input logic cur, input logic prev,
                                      input logic both, input logic pol);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (both) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Level test: pin matches the selected active level.
  function automatic logic level_match(input logic cur, input logic pol);
    return ~(cur ^ pol);
  endfunction

endpackage

// File: rtl/gpio_irq_cfg_regs.sv
module gpio_irq_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      mode_q,
  output logic [N-1:0]      both_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      ack_pulse
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_MODE: mode_q <= wdata;
        REG_BOTH: both_q <= wdata;
        REG_POL:  pol_q  <= wdata;
        REG_EN:   en_q   <= wdata;
        default: ;
      endcase
    end
  end

  assign ack_pulse = (wr_en && sel == REG_ACK) ? wdata : '0;

  // R1: configuration is clear on the cycle after any reset cycle
  a_r1_reset_clean: assert property (@(posedge clk)
    !rst_n |=> (mode_q == '0 && both_q == '0 && pol_q == '0 && en_q == '0));

  // R2: writes to the status indices leave the configuration untouched
  a_r2_status_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == REG_RAW || sel == REG_MASKED)) |=>
      ($stable(mode_q) && $stable(both_q) && $stable(pol_q) && $stable(en_q)));

endmodule

// File: rtl/gpio_irq_pin_detect.sv
module gpio_irq_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic level_mode,
  input  logic both_sel,
  input  logic pol_sel,
  input  logic ack,
  output logic raw
);

  logic pin_prev;
  logic flag_q;
  logic edge_hit;

  assign edge_hit = ~level_mode & edge_event(pin, pin_prev, both_sel, pol_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      pin_prev <= pin;
      if (edge_hit)  flag_q <= 1'b1;
      else if (ack)  flag_q <= 1'b0;
    end
  end

  assign raw = level_mode ? level_match(pin, pol_sel) : flag_q;

  // R4: a flag is only ever set by a detected transition
  a_r4_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(edge_hit));

  // R6: a flag without an acknowledge stays held
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack) |=> flag_q);

  // R6: acknowledge without a coincident transition clears the flag
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_hit) |=> !flag_q);

  // R7: a transition always leaves the flag set, acknowledge or not
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> flag_q);

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pin_in,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  output logic              irq_out
);

  logic [N-1:0] mode_q, both_q, pol_q, en_q, ack_pulse;
  logic [N-1:0] raw_stat;
  logic [N-1:0] masked_stat;

  gpio_irq_cfg_regs #(.N(N)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .mode_q    (mode_q),
    .both_q    (both_q),
    .pol_q     (pol_q),
    .en_q      (en_q),
    .ack_pulse (ack_pulse)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    gpio_irq_pin_detect u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (pin_in[i]),
      .level_mode (mode_q[i]),
      .both_sel   (both_q[i]),
      .pol_sel    (pol_q[i]),
      .ack        (ack_pulse[i]),
      .raw        (raw_stat[i])
    );
  end

  assign masked_stat = raw_stat & en_q;
  assign irq_out     = |masked_stat;

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_MODE:   bus_rdata = mode_q;
      REG_BOTH:   bus_rdata = both_q;
      REG_POL:    bus_rdata = pol_q;
      REG_EN:     bus_rdata = en_q;
      REG_RAW:    bus_rdata = raw_stat;
      REG_MASKED: bus_rdata = masked_stat;
      default:    bus_rdata = '0;
    endcase
  end

  // R9: with every enable bit clear the interrupt line stays low
  a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out);

endmodule

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_detect #(.N(8)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  localparam logic [2:0] A_MODE = 3'd0, A_BOTH = 3'd1, A_POL = 3'd2, A_EN = 3'd3,
                         A_RAW = 3'd4, A_MSK = 3'd5, A_ACK = 3'd6, A_SPARE = 3'd7;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    @(posedge clk);
  endtask

  task automatic clean();
    wr(A_MODE, 8'h00); wr(A_BOTH, 8'h00); wr(A_POL, 8'h00); wr(A_EN, 8'h00);
    wr(A_ACK, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset irq", {7'd0, irq_out}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(A_MODE, 8'hA5); rd(A_MODE, d); chk("R2 mode readback", d, 8'hA5);
    wr(A_BOTH, 8'h3C); rd(A_BOTH, d); chk("R2 both readback", d, 8'h3C);
    wr(A_POL, 8'h0F);  rd(A_POL, d);  chk("R2 pol readback", d, 8'h0F);
    wr(A_EN, 8'h81);   rd(A_EN, d);   chk("R2 enable readback", d, 8'h81);
    clean();
    wr(A_RAW, 8'hFF); rd(A_RAW, d); chk("R2 raw write ignored", d, 8'h00);
    wr(A_MSK, 8'hFF); rd(A_MSK, d); chk("R2 masked write ignored", d, 8'h00);
    rd(A_MODE, d); chk("R2 status write leaves mode", d, 8'h00);
    rd(A_EN, d);   chk("R2 status write leaves enable", d, 8'h00);
    wr(A_ACK, 8'hFF); rd(A_ACK, d); chk("R2 ack index reads 0", d, 8'h00);
    wr(A_SPARE, 8'hFF); rd(A_SPARE, d); chk("R2 spare reads 0", d, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] pol = 8'hF0;
    logic [7:0] pats [3] = '{8'h00, 8'hF0, 8'h33};
    wr(A_POL, pol); wr(A_MODE, 8'hFF);
    foreach (pats[k]) begin
      @(negedge clk);
      bus_addr = A_RAW; pin_in = pats[k];
      #1 chk("R3 level same cycle", bus_rdata, ~(pats[k] ^ pol));
    end
    set_pins(8'h00);
    @(negedge clk); #1 chk("R3 level drops, no ack", bus_rdata, ~(8'h00 ^ pol));
    clean();
  endtask

  task automatic t_edge();
    logic [7:0] d;
    wr(A_POL, 8'h0F);
    @(negedge clk);
    bus_addr = A_RAW; pin_in = 8'hFF;
    #1 chk("R4 not visible before clock", bus_rdata, 8'h00);
    @(posedge clk);
    rd(A_RAW, d); chk("R4 rising captured on pol=1", d, 8'h0F);
    set_pins(8'h00);
    rd(A_RAW, d); chk("R4 falling captured on pol=0", d, 8'hFF);
    wr(A_ACK, 8'hFF);
    set_pins(8'hFF); wr(A_ACK, 8'hF0);
    rd(A_RAW, d); chk("R4 rising ignored on pol=0", d, 8'h0F);
    set_pins(8'h00);
    clean();
  endtask

  task automatic t_both();
    logic [7:0] d;
    wr(A_BOTH, 8'hFF); wr(A_POL, 8'h00);
    set_pins(8'h55);
    rd(A_RAW, d); chk("R5 both-edge rising", d, 8'h55);
    wr(A_ACK, 8'hFF);
    wr(A_POL, 8'hFF);
    set_pins(8'h00);
    rd(A_RAW, d); chk("R5 both-edge falling, pol ignored", d, 8'h55);
    clean();
  endtask

  task automatic t_ack();
    logic [7:0] d;
    wr(A_BOTH, 8'hFF);
    set_pins(8'hFF);
    wr(A_ACK, 8'h00);
    rd(A_RAW, d); chk("R6 zero ack keeps flags", d, 8'hFF);
    wr(A_ACK, 8'h0F);
    repeat (5) @(posedge clk);
    rd(A_RAW, d); chk("R6 partial ack, rest held", d, 8'hF0);
    wr(A_ACK, 8'hF0);
    rd(A_RAW, d); chk("R6 ack clears", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    // pins at FF, both-edge on for all pins
    @(negedge clk);
    pin_in = 8'hFE;
    bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 8'h01;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    rd(A_RAW, d); chk("R7 edge wins over ack", d, 8'h01);
    wr(A_ACK, 8'h01);
    rd(A_RAW, d); chk("R7 later ack clears", d, 8'h00);
    set_pins(8'h00); wr(A_ACK, 8'hFF);
    clean();
  endtask

  task automatic t_cfg_keep();
    logic [7:0] d;
    wr(A_BOTH, 8'hFF);
    set_pins(8'h0F);
    wr(A_BOTH, 8'h00); wr(A_POL, 8'hFF);
    rd(A_RAW, d); chk("R8 config rewrite keeps flags", d, 8'h0F);
    wr(A_POL, 8'h00); wr(A_MODE, 8'hFF);
    rd(A_RAW, d); chk("R8 level view while flags held", d, ~(8'h0F ^ 8'h00));
    wr(A_MODE, 8'h00);
    rd(A_RAW, d); chk("R8 flags return in edge mode", d, 8'h0F);
    set_pins(8'h00);
    clean();
  endtask

  task automatic t_mask();
    logic [7:0] d;
    logic [7:0] raw = 8'h3C;
    logic [7:0] ens [4] = '{8'h00, 8'h04, 8'hC3, 8'hFF};
    wr(A_BOTH, 8'hFF);
    set_pins(raw);
    foreach (ens[k]) begin
      wr(A_EN, ens[k]);
      rd(A_MSK, d); chk("R9 masked status", d, raw & ens[k]);
      chk("R9 irq line", {7'd0, irq_out}, {7'd0, |(raw & ens[k])});
    end
    wr(A_ACK, raw);
    rd(A_MSK, d); chk("R9 irq after ack", {7'd0, irq_out}, 8'h00);
    set_pins(8'h00);
    clean();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_both();
    t_ack();
    t_collide();
    t_cfg_keep();
    t_mask();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule